// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block takes one control-flow decision per instruction. For each request it receives the current program counter, the 32-bit instruction word and the values of its two source registers. From these it works out the address of the next instruction and whether control flow was redirected. For the link forms it also produces a write of the return address to register 31. It handles the two-register compare branches, the signed compare-against-zero branches (including the linking variants selected by the rt field), the region jump, the region jump with link, and the register-indirect jump. Any other instruction simply steps the counter by one word.

Requests enter on a valid/ready input stream and results leave on a valid/ready output stream through a single register stage. The upstream side may present a request whenever it likes. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when it is being drained in that same cycle. That gives full throughput while the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the held result does not change and no new request is taken. After a register-indirect jump, the consumer watches a separate flag that reports a target that is not word aligned.

Top module: `ctl_flow_npc`

## Requirements
- R1: An instruction that is not one of the handled control transfers gives next PC = PC + 4, taken = 0, link write = 0 and misaligned = 0.
- R2: Opcode 000100 (equal) and opcode 000101 (not equal) compare rs with rt. When the condition holds, next PC = PC + 4 + (sign-extended imm[15:0] << 2) and taken = 1. Otherwise next PC = PC + 4 and taken = 0.
- R3: Opcode 000110 takes the branch when rs is less than or equal to zero, and opcode 000111 takes it when rs is greater than zero. Both compare rs as a signed value and use the target rule of R2.
- R4: Opcode 000001 selects its condition by rt = instr[20:16]. Code 00000 branches if rs < 0, code 00001 if rs >= 0, code 10000 if rs < 0 with link, and code 10001 if rs >= 0 with link. Any other code behaves as in R1.
- R5: Opcode 000010 and opcode 000011 always take the jump, with next PC = {PC[31:28], instr[25:0], 2'b00}.
- R6: Opcode 000011 and the two linking codes of R4 assert the link write with link value PC + 8. They do so whether or not the branch is taken. No other instruction asserts the link write.
- R7: Opcode 000000 with funct instr[5:0] = 001000 always takes the jump, with next PC = rs. Its misaligned flag is 1 exactly when rs[1:0] is not 00. Every other instruction leaves the flag at 0.
- R8: A request accepted on a clock edge appears on the outputs with `out_valid` high after that edge. `in_ready` = !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, all result outputs stay unchanged.
- R9: While reset is asserted, and after it is released until the first acceptance, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_pc | input | 32 | Address of the instruction |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the rs register |
| in_rt_val | input | 32 | Value of the rt register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 32 | Address of the next instruction |
| out_taken | output | 1 | Control flow redirected |
| out_link_we | output | 1 | Write link value to register 31 |
| out_link_val | output | 32 | Return address (PC + 8) |
| out_misalign | output | 1 | Register-indirect target not word aligned |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request, and it stays on the outputs until a cycle with `out_ready` high drains it. The bench keeps a behavioural model of the output register. On each falling edge it compares `in_ready`, `out_valid` and, when the result is valid, every result field against that model. After the compare it drives fresh inputs and decides from them what the model will hold after the coming rising edge. A random back-pressure pattern on `out_ready` exercises the hold rule, and operand choices such as zero, the most negative value and equal operands land on the edge of each compare.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN    = 32;
  localparam int IMM_W   = 16;
  localparam int IDX_W   = 26;
  localparam int REGN_W  = 5;
  localparam int OP_W    = 6;
  localparam int REGION_W = XLEN - IDX_W - 2;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
  localparam logic [OP_W-1:0] OP_J       = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OP_BLEZ    = 6'b000110;
  localparam logic [OP_W-1:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0]      FN_JR      = 6'b001000;

  localparam logic [REGN_W-1:0] RI_LTZ   = 5'b00000;
  localparam logic [REGN_W-1:0] RI_GEZ   = 5'b00001;
  localparam logic [REGN_W-1:0] RI_LTZL  = 5'b10000;
  localparam logic [REGN_W-1:0] RI_GEZL  = 5'b10001;

  typedef enum logic [3:0] {
    K_SEQ, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ,
    K_LTZL, K_GEZL, K_JMP, K_JMPL, K_JREG
  } ctl_kind_e;

  typedef struct packed {
    logic [XLEN-1:0] next_pc;
    logic            taken;
    logic            link_we;
    logic [XLEN-1:0] link_val;
    logic            misalign;
  } npc_res_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctl_kind_e       kind
);
  logic [OP_W-1:0]   op;
  logic [REGN_W-1:0] rt_f;
  logic [5:0]        fn;

  assign op   = instr[XLEN-1 -: OP_W];
  assign rt_f = instr[20:16];
  assign fn   = instr[5:0];

  always_comb begin
    kind = K_SEQ;
    case (op)
      OP_SPECIAL: if (fn == FN_JR) kind = K_JREG;
      OP_REGIMM: begin
        case (rt_f)
          RI_LTZ:  kind = K_LTZ;
          RI_GEZ:  kind = K_GEZ;
          RI_LTZL: kind = K_LTZL;
          RI_GEZL: kind = K_GEZL;
          default: kind = K_SEQ;
        endcase
      end
      OP_J:    kind = K_JMP;
      OP_JAL:  kind = K_JMPL;
      OP_BEQ:  kind = K_EQ;
      OP_BNE:  kind = K_NE;
      OP_BLEZ: kind = K_LEZ;
      OP_BGTZ: kind = K_GTZ;
      default: kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  ctl_kind_e       kind,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            go
);
  logic neg, zero, same;

  assign neg  = rs_val[XLEN-1];
  assign zero = (rs_val == '0);
  assign same = (rs_val == rt_val);

  always_comb begin
    case (kind)
      K_EQ:                 go = same;
      K_NE:                 go = !same;
      K_LEZ:                go = neg || zero;
      K_GTZ:                go = !neg && !zero;
      K_LTZ, K_LTZL:        go = neg;
      K_GEZ, K_GEZL:        go = !neg;
      K_JMP, K_JMPL, K_JREG: go = 1'b1;
      default:              go = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  ctl_kind_e       kind,
  input  logic            go,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  output npc_res_t        res
);
  localparam int SEXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] seq_pc, br_off, br_pc, reg_pc;
  logic            is_branch;

  assign seq_pc = pc + XLEN'(4);
  assign br_off = {{SEXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
  assign br_pc  = seq_pc + br_off;
  assign reg_pc = {pc[XLEN-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};

  assign is_branch = (kind == K_EQ) || (kind == K_NE) || (kind == K_LEZ) ||
                     (kind == K_GTZ) || (kind == K_LTZ) || (kind == K_GEZ) ||
                     (kind == K_LTZL) || (kind == K_GEZL);

  always_comb begin
    res.next_pc = seq_pc;
    if (is_branch && go)                        res.next_pc = br_pc;
    else if (kind == K_JMP || kind == K_JMPL)   res.next_pc = reg_pc;
    else if (kind == K_JREG)                    res.next_pc = rs_val;
    res.taken    = go;
    res.link_we  = (kind == K_JMPL) || (kind == K_LTZL) || (kind == K_GEZL);
    res.link_val = pc + XLEN'(8);
    res.misalign = (kind == K_JREG) && (rs_val[1:0] != 2'b00);
  end
endmodule

// File: rtl/npc_outreg.sv
module npc_outreg
  import npc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  npc_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output npc_res_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end

  // R8: held result does not move under back-pressure
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));

  // R8: accepted request shows up after the accepting edge
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: no result without a prior acceptance
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);
endmodule

// File: rtl/ctl_flow_npc.sv
module ctl_flow_npc
  import npc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_rs_val,
  input  logic [XLEN-1:0] in_rt_val,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_taken,
  output logic            out_link_we,
  output logic [XLEN-1:0] out_link_val,
  output logic            out_misalign
);
  ctl_kind_e kind;
  logic      go;
  npc_res_t  res, held;

  npc_decode u_dec (.instr(in_instr), .kind(kind));

  npc_cond u_cond (.kind(kind), .rs_val(in_rs_val), .rt_val(in_rt_val), .go(go));

  npc_target u_tgt (.kind(kind), .go(go), .pc(in_pc), .instr(in_instr),
                    .rs_val(in_rs_val), .res(res));

  npc_outreg u_oreg (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                     .in_res(res), .out_valid(out_valid), .out_ready(out_ready),
                     .out_res(held));

  assign out_next_pc  = held.next_pc;
  assign out_taken    = held.taken;
  assign out_link_we  = held.link_we;
  assign out_link_val = held.link_val;
  assign out_misalign = held.misalign;

  // R1: a non-redirected instruction steps by one word
  p_seq_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !res.taken |-> res.next_pc == in_pc + 32'd4);

  // R6: a link write always carries the address two words on
  p_link_pc8_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && res.link_we |-> res.link_val == in_pc + 32'd8);

  // R7: a misaligned flag only comes with a redirect to an unaligned address
  p_misalign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && res.misalign |-> res.taken && (res.next_pc[1:0] != 2'b00));

  // R5: region jumps keep the upper PC bits
  p_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_instr[31:27] == 5'b00001) |->
      res.taken && res.next_pc[31:28] == in_pc[31:28]);
endmodule

// File: tb/ctl_flow_npc_tb.sv
module ctl_flow_npc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_pc, in_instr, in_rs_val, in_rt_val;
  logic [31:0] out_next_pc, out_link_val;
  logic        out_taken, out_link_we, out_misalign;

  int vectors = 0;
  int fails   = 0;

  // model of the output register
  logic        m_valid;
  logic [31:0] m_next, m_lval;
  logic        m_taken, m_lwe, m_mis;
  string       m_tag;

  always #2.5 clk = ~clk;

  ctl_flow_npc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_instr(in_instr), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_taken(out_taken), .out_link_we(out_link_we), .out_link_val(out_link_val),
    .out_misalign(out_misalign));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic ref_model(input logic [31:0] pc, input logic [31:0] ins,
                           input logic [31:0] rs, input logic [31:0] rt,
                           output logic [31:0] nxt, output logic tk,
                           output logic lwe, output logic [31:0] lval,
                           output logic mis, output string tag);
    int   op  = int'(ins[31:26]);
    int   sub = int'(ins[20:16]);
    int   srs = $signed(rs);
    logic [31:0] off = {{14{ins[15]}}, ins[15:0], 2'b00};
    logic cond = 1'b0;
    logic br = 1'b0;
    nxt = pc + 4; tk = 0; lwe = 0; mis = 0; lval = pc + 8; tag = "R1";
    if (op == 4)       begin br = 1; cond = (rs == rt);  tag = "R2"; end
    else if (op == 5)  begin br = 1; cond = (rs != rt);  tag = "R2"; end
    else if (op == 6)  begin br = 1; cond = (srs <= 0);  tag = "R3"; end
    else if (op == 7)  begin br = 1; cond = (srs > 0);   tag = "R3"; end
    else if (op == 1) begin
      tag = "R4";
      if (sub == 0)       begin br = 1; cond = (srs < 0); end
      else if (sub == 1)  begin br = 1; cond = (srs >= 0); end
      else if (sub == 16) begin br = 1; cond = (srs < 0); lwe = 1; end
      else if (sub == 17) begin br = 1; cond = (srs >= 0); lwe = 1; end
    end else if (op == 2 || op == 3) begin
      tag = "R5"; tk = 1; nxt = {pc[31:28], ins[25:0], 2'b00}; lwe = (op == 3);
    end else if (op == 0 && ins[5:0] == 6'b001000) begin
      tag = "R7"; tk = 1; nxt = rs; mis = (rs[1:0] != 2'b00);
    end
    if (br && cond) begin tk = 1; nxt = pc + 4 + off; end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 7)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] make_instr();
    logic [31:0] r = $urandom;
    logic [4:0]  codes [5] = '{5'b00000, 5'b00001, 5'b10000, 5'b10001, 5'b00010};
    case ($urandom % 11)
      0: return {6'b000100, r[25:0]};
      1: return {6'b000101, r[25:0]};
      2: return {6'b000110, r[25:21], 5'b0, r[15:0]};
      3: return {6'b000111, r[25:21], 5'b0, r[15:0]};
      4, 5: return {6'b000001, r[25:21], codes[$urandom % 5], r[15:0]};
      6: return {6'b000010, r[25:0]};
      7: return {6'b000011, r[25:0]};
      8: return {6'b000000, r[25:21], 15'b0, 6'b001000};
      9: return {6'b000000, r[25:6], 6'b100001};
      default: return {6'b001000, r[25:0]};
    endcase
  endfunction

  task automatic compare_outputs();
    chk("R8", "in_ready", {31'b0, in_ready}, {31'b0, !m_valid || out_ready});
    chk(m_valid ? "R8" : "R9", "out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    if (m_valid) begin
      chk(m_tag, "next_pc", out_next_pc, m_next);
      chk(m_tag, "taken", {31'b0, out_taken}, {31'b0, m_taken});
      chk("R6", "link_we", {31'b0, out_link_we}, {31'b0, m_lwe});
      if (m_lwe) chk("R6", "link_val", out_link_val, m_lval);
      chk("R7", "misalign", {31'b0, out_misalign}, {31'b0, m_mis});
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] ins,
                      input logic [31:0] rs, input logic [31:0] rt, input logic ordy);
    logic [31:0] nx, lv;
    logic tk, lw, ms;
    string tg;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_pc = pc; in_instr = ins; in_rs_val = rs; in_rt_val = rt;
    out_ready = ordy;
    if (v && (!m_valid || ordy)) begin
      ref_model(pc, ins, rs, rt, nx, tk, lw, lv, ms, tg);
      m_valid = 1; m_next = nx; m_taken = tk; m_lwe = lw; m_lval = lv; m_mis = ms;
      m_tag = tg;
    end else if (ordy) begin
      m_valid = 0;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_pc = 0; in_instr = 0; in_rs_val = 0; in_rt_val = 0;
    m_valid = 0; m_next = 0; m_lval = 0; m_taken = 0; m_lwe = 0; m_mis = 0; m_tag = "R9";
    repeat (3) @(negedge clk);
    chk("R9", "out_valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1;
    // directed corners
    step(1, 32'h0000_1000, 32'h0000_0020, 5, 6, 1);                 // R1 add
    step(1, 32'h0000_1000, {6'd4, 10'd0, 16'hFFFF}, 7, 7, 1);       // R2 beq back
    step(1, 32'h0000_1000, {6'd5, 10'd0, 16'h0010}, 7, 7, 1);       // R2 bne not taken
    step(1, 32'h0000_2000, {6'd6, 10'd0, 16'h0004}, 0, 0, 1);       // R3 lez at zero
    step(1, 32'h0000_2000, {6'd7, 10'd0, 16'h0004}, 0, 0, 1);       // R3 gtz at zero
    step(1, 32'h0000_2000, {6'd7, 10'd0, 16'h0004}, 32'h8000_0000, 0, 1);
    step(1, 32'h0000_3000, {6'd1, 5'd0, 5'b10000, 16'h0008}, 1, 0, 1);  // R6 link not taken
    step(1, 32'h0000_3000, {6'd1, 5'd0, 5'b10001, 16'h8000}, 0, 0, 1);  // R4 gez link at zero
    step(1, 32'h0000_3000, {6'd1, 5'd0, 5'b00011, 16'h0008}, 0, 0, 1);  // R4 unknown code
    step(1, 32'hA000_0040, {6'd3, 26'h3FF_FFFF}, 0, 0, 1);          // R5 jal region
    step(1, 32'h5000_0000, {6'd2, 26'h000_0001}, 0, 0, 1);          // R5 j
    step(1, 32'h0000_4000, 32'h03E0_0008, 32'h0000_8002, 0, 1);      // R7 jr misaligned
    step(1, 32'h0000_4000, 32'h03E0_0008, 32'h0000_8000, 0, 0);      // R7 aligned, R8 stall
    step(1, 32'h0000_5000, 32'h0000_0000, 0, 0, 0);                  // R8 held
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // random mix with back-pressure
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a = pick_val();
      logic [31:0] b = ($urandom % 2) ? a : pick_val();
      step(($urandom % 4) != 0, {$urandom} & 32'hFFFF_FFFC, make_instr(), a, b,
           ($urandom % 3) != 0);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule